// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two 16-bit buses, side A and side B, as a pair of independent 8-bit lanes. Each lane has one storage element for traffic going from A to B and a second one for traffic going from B to A. Each direction has its own three active-low controls: select, hold and drive. A lane can pass data straight from one side to the other. It can also capture a word and present it later, while the source side is free to change.

The three-state pins are split into an input vector, an output vector and a per-lane drive flag for each side. This keeps everything inside ordinary synthesizable logic. The storage elements are updated on the rising clock edge, and the outputs are combinational from the inputs and the stored words. Each lane also flags contention. This happens when the block drives a side of that lane while the surrounding logic reports that it is driving the same side.

The block has no streaming payload. Data moves level by level under its control pins, so it has no valid/ready handshake and applies no back-pressure.

Top module: `bxcvr_top`

## Requirements
- R1: A synchronous active-high reset clears the stored word of every direction in every lane to zero. After reset, a direction that has select low, hold high and drive low outputs 8'h00.
- R2: When a direction's select, hold and drive inputs are all low, its output lane equals the current source-side input in the same cycle.
- R3: At every rising clock edge where select and hold are both low, the stored word takes the source input. Once hold goes high, the output keeps showing the word sampled at the last such edge, whatever the source does afterwards.
- R4: While select is high, the stored word does not change, whatever hold does. The output lane is not driven.
- R5: With select low and drive high, the output lane is not driven, but the stored word still follows the source while hold is low. A later enable with hold high shows that word.
- R6: A direction's drive flag is 1 exactly when both its select and drive inputs are low. An undriven output lane reads 8'h00.
- R7: The B-to-A direction follows R2 to R6 with its own three controls and side A as its output. It does not depend on the A-to-B controls.
- R8: Each lane's controls act only on that lane. Lane 0 uses bits 7:0 of each data vector and bit 0 of each control and flag vector; lane 1 uses bits 15:8 and bit 1.
- R9: A lane's contention flag is 1 in the same cycle when that lane drives side A while a_ext_drv for that lane is 1, or drives side B while b_ext_drv for that lane is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the storage elements |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 16 | Value present on side A |
| b_in | input | 16 | Value present on side B |
| ab_sel_n | input | 2 | A-to-B select per lane, active low |
| ab_hold_n | input | 2 | A-to-B hold per lane, active low (low = pass-through) |
| ab_drv_n | input | 2 | A-to-B drive per lane, active low |
| ba_sel_n | input | 2 | B-to-A select per lane, active low |
| ba_hold_n | input | 2 | B-to-A hold per lane, active low (low = pass-through) |
| ba_drv_n | input | 2 | B-to-A drive per lane, active low |
| a_ext_drv | input | 2 | Per lane: something outside drives side A |
| b_ext_drv | input | 2 | Per lane: something outside drives side B |
| a_out | output | 16 | Value the block places on side A |
| a_oe | output | 2 | Per lane: block drives side A |
| b_out | output | 16 | Value the block places on side B |
| b_oe | output | 2 | Per lane: block drives side B |
| clash | output | 2 | Per lane: contention detected |

## Verification
The output values, drive flags and contention flags are combinational. They are due in the same cycle as the control and data change. The bench changes its inputs on the falling edge and samples 1 ns later, before the next rising edge. A capture becomes visible one rising edge after the inputs that cause it. The bench's reference model updates its stored words right after each rising edge, from the inputs held stable across that edge. Later samples then compare against words that the design has already taken in the same way.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned LANES_DEF  = 2;

  typedef struct packed {
    logic sel_n;
    logic hold_n;
    logic drv_n;
  } dir_ctl_t;
endpackage

// File: rtl/bxcvr_dir_latch.sv
module bxcvr_dir_latch #(
  parameter int unsigned W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  bxcvr_pkg::dir_ctl_t   ctl,
  input  logic [W-1:0]          din,
  output logic [W-1:0]          dout,
  output logic                  drive
);
  logic [W-1:0] store;
  logic         open_w;

  assign open_w = !ctl.sel_n && !ctl.hold_n;

  always_ff @(posedge clk) begin
    if (rst)         store <= '0;
    else if (open_w) store <= din;
  end

  assign drive = !ctl.sel_n && !ctl.drv_n;
  assign dout  = drive ? (open_w ? din : store) : '0;

  // R3: while hold is high the word is kept
  p_hold_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.hold_n |=> $stable(store));
  // R4: deselected direction never changes its word
  p_desel_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.sel_n |=> $stable(store));
  // R3: an open edge captures the source value
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctl.sel_n && !ctl.hold_n) |=> store == $past(din));
  // R6: an undriven lane stays quiet
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.sel_n |-> (dout == '0));
endmodule

// File: rtl/bxcvr_lane.sv
module bxcvr_lane #(
  parameter int unsigned W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [W-1:0]        a_in,
  input  logic [W-1:0]        b_in,
  input  bxcvr_pkg::dir_ctl_t ab_ctl,
  input  bxcvr_pkg::dir_ctl_t ba_ctl,
  input  logic                a_ext,
  input  logic                b_ext,
  output logic [W-1:0]        a_out,
  output logic                a_oe,
  output logic [W-1:0]        b_out,
  output logic                b_oe,
  output logic                clash
);
  bxcvr_dir_latch #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .ctl(ab_ctl), .din(a_in), .dout(b_out), .drive(b_oe)
  );

  bxcvr_dir_latch #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .ctl(ba_ctl), .din(b_in), .dout(a_out), .drive(a_oe)
  );

  assign clash = (a_oe && a_ext) || (b_oe && b_ext);

  // R2: pass-through A to B shows the live A value
  p_pass_ab_r2: assert property (@(posedge clk) disable iff (rst)
    (b_oe && !ab_ctl.hold_n) |-> (b_out == a_in));
  // R7: pass-through B to A shows the live B value
  p_pass_ba_r7: assert property (@(posedge clk) disable iff (rst)
    (a_oe && !ba_ctl.hold_n) |-> (a_out == b_in));
  // R9: no clash flagged while neither side is driven by the block
  p_clash_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!a_oe && !b_oe) |-> !clash);
endmodule

// File: rtl/bxcvr_top.sv
module bxcvr_top #(
  parameter int unsigned LANE_W = bxcvr_pkg::LANE_W_DEF,
  parameter int unsigned LANES  = bxcvr_pkg::LANES_DEF,
  localparam int unsigned BUS_W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] a_in,
  input  logic [BUS_W-1:0] b_in,
  input  logic [LANES-1:0] ab_sel_n,
  input  logic [LANES-1:0] ab_hold_n,
  input  logic [LANES-1:0] ab_drv_n,
  input  logic [LANES-1:0] ba_sel_n,
  input  logic [LANES-1:0] ba_hold_n,
  input  logic [LANES-1:0] ba_drv_n,
  input  logic [LANES-1:0] a_ext_drv,
  input  logic [LANES-1:0] b_ext_drv,
  output logic [BUS_W-1:0] a_out,
  output logic [LANES-1:0] a_oe,
  output logic [BUS_W-1:0] b_out,
  output logic [LANES-1:0] b_oe,
  output logic [LANES-1:0] clash
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bxcvr_pkg::dir_ctl_t ab_c, ba_c;
    assign ab_c = '{sel_n: ab_sel_n[g], hold_n: ab_hold_n[g], drv_n: ab_drv_n[g]};
    assign ba_c = '{sel_n: ba_sel_n[g], hold_n: ba_hold_n[g], drv_n: ba_drv_n[g]};

    bxcvr_lane #(.W(LANE_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .a_in  (a_in[g*LANE_W +: LANE_W]),
      .b_in  (b_in[g*LANE_W +: LANE_W]),
      .ab_ctl(ab_c),
      .ba_ctl(ba_c),
      .a_ext (a_ext_drv[g]),
      .b_ext (b_ext_drv[g]),
      .a_out (a_out[g*LANE_W +: LANE_W]),
      .a_oe  (a_oe[g]),
      .b_out (b_out[g*LANE_W +: LANE_W]),
      .b_oe  (b_oe[g]),
      .clash (clash[g])
    );
  end
endmodule

// File: tb/tb_bxcvr_top.sv
`timescale 1ns/1ps
module tb_bxcvr_top;
  localparam int W = 8;
  localparam int L = 2;

  logic clk = 0;
  logic rst = 1;
  logic [W*L-1:0] a_in = '0, b_in = '0;
  logic [L-1:0] ab_sel_n = '1, ab_hold_n = '1, ab_drv_n = '1;
  logic [L-1:0] ba_sel_n = '1, ba_hold_n = '1, ba_drv_n = '1;
  logic [L-1:0] a_ext_drv = '0, b_ext_drv = '0;
  logic [W*L-1:0] a_out, b_out;
  logic [L-1:0] a_oe, b_oe, clash;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] st_ab [L];
  logic [W-1:0] st_ba [L];

  always #5 clk = ~clk;

  bxcvr_top dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_sel_n(ab_sel_n), .ab_hold_n(ab_hold_n), .ab_drv_n(ab_drv_n),
    .ba_sel_n(ba_sel_n), .ba_hold_n(ba_hold_n), .ba_drv_n(ba_drv_n),
    .a_ext_drv(a_ext_drv), .b_ext_drv(b_ext_drv),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe), .clash(clash)
  );

  task automatic chk(string tag, int lane, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s lane %0d %s: actual %h expected %h", tag, lane, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_data(logic sel_n, logic hold_n, logic drv_n,
                                            logic [W-1:0] src, logic [W-1:0] st);
    if (sel_n || drv_n) return '0;
    return hold_n ? st : src;
  endfunction

  task automatic check_all(string tag);
    for (int h = 0; h < L; h++) begin
      logic eb, ea, ec;
      eb = !ab_sel_n[h] && !ab_drv_n[h];
      ea = !ba_sel_n[h] && !ba_drv_n[h];
      ec = (ea && a_ext_drv[h]) || (eb && b_ext_drv[h]);
      chk(tag, h, "b_out", b_out[h*W +: W],
          exp_data(ab_sel_n[h], ab_hold_n[h], ab_drv_n[h], a_in[h*W +: W], st_ab[h]));
      chk(tag, h, "a_out", a_out[h*W +: W],
          exp_data(ba_sel_n[h], ba_hold_n[h], ba_drv_n[h], b_in[h*W +: W], st_ba[h]));
      chk("R6", h, "b_oe", {7'b0, b_oe[h]}, {7'b0, eb});
      chk("R6", h, "a_oe", {7'b0, a_oe[h]}, {7'b0, ea});
      chk("R9", h, "clash", {7'b0, clash[h]}, {7'b0, ec});
    end
  endtask

  // inputs set right after a falling edge; sample, then advance one cycle
  task automatic step(string tag);
    #1 check_all(tag);
    @(posedge clk);
    for (int h = 0; h < L; h++) begin
      if (rst) begin
        st_ab[h] = '0; st_ba[h] = '0;
      end else begin
        if (!ab_sel_n[h] && !ab_hold_n[h]) st_ab[h] = a_in[h*W +: W];
        if (!ba_sel_n[h] && !ba_hold_n[h]) st_ba[h] = b_in[h*W +: W];
      end
    end
    @(negedge clk);
  endtask

  task automatic set_ab(int h, logic s, logic hd, logic d);
    ab_sel_n[h] = s; ab_hold_n[h] = hd; ab_drv_n[h] = d;
  endtask
  task automatic set_ba(int h, logic s, logic hd, logic d);
    ba_sel_n[h] = s; ba_hold_n[h] = hd; ba_drv_n[h] = d;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(10 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'h1b2c3d4e));
    for (int h = 0; h < L; h++) begin st_ab[h] = 'x; st_ba[h] = 'x; end
    a_in = 16'hFFFF; b_in = 16'hFFFF;
    set_ab(0, 0, 0, 1); set_ab(1, 0, 0, 1); set_ba(0, 0, 0, 1); set_ba(1, 0, 0, 1);
    @(negedge clk);
    repeat (3) begin
      @(posedge clk);
      for (int h = 0; h < L; h++) begin st_ab[h] = '0; st_ba[h] = '0; end
      @(negedge clk);
    end
    rst = 0;
    // R1: stored words read zero after reset
    for (int h = 0; h < L; h++) begin set_ab(h, 0, 1, 0); set_ba(h, 0, 1, 0); end
    a_in = 16'h1234; b_in = 16'h5678;
    step("R1");
    // R2: live pass-through on lane 0 A to B
    a_in[7:0] = 8'hA5; set_ab(0, 0, 0, 0);
    step("R2");
    // R3: capture then hold while source changes
    set_ab(0, 0, 1, 0); a_in[7:0] = 8'h5A;
    step("R3");
    a_in[7:0] = 8'h0F;
    step("R3");
    // R4: deselected, hold low, source changes; word untouched
    set_ab(0, 1, 0, 0); a_in[7:0] = 8'hC3;
    step("R4");
    set_ab(0, 0, 1, 0);
    step("R4");
    // R5: drive off, still tracking, then show
    set_ab(0, 0, 0, 1); a_in[7:0] = 8'h3C;
    step("R5");
    set_ab(0, 0, 1, 0); a_in[7:0] = 8'h99;
    step("R5");
    // R7: B to A pass and capture on lane 1, with A-to-B off
    set_ab(1, 1, 1, 1); set_ba(1, 0, 0, 0); b_in[15:8] = 8'h66;
    step("R7");
    set_ba(1, 0, 1, 0); b_in[15:8] = 8'h77;
    step("R7");
    // R8: lane 0 passes while lane 1 holds
    set_ab(0, 0, 0, 0); set_ab(1, 0, 1, 0); a_in = 16'hE1D2;
    step("R8");
    // R9: contention on both sides
    set_ba(0, 0, 0, 0); a_ext_drv = 2'b01; b_ext_drv = 2'b10;
    step("R9");
    a_ext_drv = 2'b00; b_ext_drv = 2'b00;
    step("R9");
    // random mix, lanes independent
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      ab_sel_n = r[1:0]; ab_hold_n = r[3:2]; ab_drv_n = r[5:4];
      ba_sel_n = r[7:6]; ba_hold_n = r[9:8]; ba_drv_n = r[11:10];
      a_ext_drv = r[13:12] & r[15:14]; b_ext_drv = r[17:16] & r[19:18];
      a_in = 16'($urandom); b_in = 16'($urandom);
      step((i % 2) ? "R7" : "R8");
    end
    finish_up();
  end
endmodule